// File: doc/BRIEF.md
# Per-Line Register Protection Filter

This block sits between a simple register bus and two banks of per-line configuration registers. Each line carries two attributes of its own: a secure bit and a privileged bit. Each access carries secure and privileged flags. The filter compares them line by line. It masks write data, so that protected bits keep their old value. It clears read data for the lines that the access may not see. It also raises a one-cycle illegal-access pulse when an access breaks a rule that requires one.

There are two kinds of protected register. In the bit-per-line bank, bit `b` of every word belongs to line `b`. In the byte-per-line bank, byte lane `k` of word `w` belongs to line `4*w+k`; this is the layout a per-line source selector uses. The filter owns three registers of its own: a security attribute register, a privilege attribute register and a lock register. The two attribute registers guard each other. The lock, once set, freezes both of them.

Requests arrive as a valid strobe with no ready: the filter accepts a request in every cycle and never stalls. A read produces a response strobe one cycle later. That response cannot be back-pressured, so the requester must take it in the cycle it appears. Writes produce no response.

Top module: `line_guard_filter`

## Requirements
- R1: A line whose secure attribute is set keeps its bits unchanged on writes from non-secure accesses, and non-secure reads of those bits return 0.
- R2: A line whose privilege attribute is set keeps its bits unchanged on writes from unprivileged accesses, and unprivileged reads of those bits return 0.
- R3: A line with both attributes clear is read and written by any access; bits at positions of NUM_LINES and above read 0 and are never written.
- R4: In the byte-per-line bank, byte lane k (bits 8k+7..8k) of word w belongs to line 4w+k and is filtered as a whole by that line's attributes; lanes whose line number is NUM_LINES or more read 0 and keep 0.
- R5: A write updates only the bytes whose byte enable is set (req_be bit k covers bits 8k+7..8k); the other bytes keep their contents, and the per-line mask is applied after this merge.
- R6: The security attribute register (bit l for line l) takes writes only from secure accesses. A non-secure write leaves it unchanged and raises the illegal pulse. Any access reads its contents. A line whose privilege attribute is set lets only a privileged access change that line's secure bit.
- R7: The privilege attribute register (bit l for line l) takes writes only from privileged accesses. An unprivileged write leaves it unchanged, and an unprivileged read still returns its contents. A line whose secure attribute is set lets only a secure access change that line's privilege bit.
- R8: The lock register (bit 0) is reachable only by secure accesses. A non-secure write is ignored and a non-secure read returns 0, and both raise the illegal pulse.
- R9: The lock bit is set by a secure write of 1 to bit 0 and never clears until reset; writing 0 has no effect. While it is set, neither attribute register changes.
- R10: illegal_pulse is high for exactly the one cycle after each offending request and low after every other request or idle cycle.
- R11: rsp_valid is high for exactly the one cycle after each read request and carries the filtered read data; writes and idle cycles give rsp_valid low.
- R12: The map uses word addresses req_addr[7:2]. 0x00-0x3C is the bit-per-line bank and 0x40-0x7C the byte-per-line bank, with bank_word = req_addr[5:2]. 0x80 holds the security attributes, 0x84 the privilege attributes and 0x88 the lock. Every other address reads 0 and ignores writes. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted every cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address, word aligned |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Access is secure |
| req_priv | input | 1 | Access is privileged |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 32 | Filtered read data |
| illegal_pulse | output | 1 | One-cycle illegal-access event |
| bank_wr_bit | output | 1 | Write strobe for the bit-per-line bank |
| bank_wr_byte | output | 1 | Write strobe for the byte-per-line bank |
| bank_word | output | 4 | Word index within the addressed bank |
| bank_wdata | output | 32 | Full word to store, protected bits already restored |
| bit_bank_rdata | input | 32 | Current contents of bit-bank word bank_word |
| byte_bank_rdata | input | 32 | Current contents of byte-bank word bank_word |

## Verification
The assertions assume that both bank read-data inputs show, in the same cycle, the current contents of the word that bank_word selects. They also assume that the access flags are valid whenever req_valid is high. The merge and the write-protection properties compare bank_wdata against those inputs, so a bank that returned stale data would break them. The bench models each bank as a word array indexed combinationally by bank_word and updated on the clock edge from the bank write strobes. It drives every request at the falling edge and removes it right after the next rising edge, so each request lasts exactly one cycle.

// File: rtl/lgf_pkg.sv
package lgf_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int WIDX_W = 4;

  localparam logic [5:0] WADDR_SEC  = 6'h20;
  localparam logic [5:0] WADDR_PRIV = 6'h21;
  localparam logic [5:0] WADDR_LOCK = 6'h22;

  typedef enum logic [2:0] {
    RGN_BITBANK,
    RGN_BYTEBANK,
    RGN_SECATTR,
    RGN_PRIVATTR,
    RGN_LOCK,
    RGN_NONE
  } region_e;

  function automatic region_e decode_region(input logic [ADDR_W-1:2] waddr);
    region_e r;
    if (waddr[ADDR_W-1:ADDR_W-2] == 2'b00)      r = RGN_BITBANK;
    else if (waddr[ADDR_W-1:ADDR_W-2] == 2'b01) r = RGN_BYTEBANK;
    else if (waddr == WADDR_SEC)               r = RGN_SECATTR;
    else if (waddr == WADDR_PRIV)              r = RGN_PRIVATTR;
    else if (waddr == WADDR_LOCK)              r = RGN_LOCK;
    else                                       r = RGN_NONE;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] expand_be(input logic [BE_W-1:0] be);
    logic [DATA_W-1:0] m;
    for (int k = 0; k < BE_W; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction
endpackage

// File: rtl/lgf_line_rights.sv
module lgf_line_rights #(
  parameter int NUM_LINES = 19
) (
  input  logic [NUM_LINES-1:0] sec_attr,
  input  logic [NUM_LINES-1:0] priv_attr,
  input  logic                 acc_secure,
  input  logic                 acc_priv,
  output logic [NUM_LINES-1:0] allow
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign allow[l] = (~sec_attr[l] | acc_secure) & (~priv_attr[l] | acc_priv);
  end
endmodule

// File: rtl/lgf_lane_map.sv
module lgf_lane_map #(
  parameter int NUM_LINES     = 19,
  parameter bit BYTE_PER_LINE = 1'b0,
  parameter int WIDX_W        = 4
) (
  input  logic [NUM_LINES-1:0] allow,
  input  logic [WIDX_W-1:0]    word,
  output logic [31:0]          mask
);
  localparam int SPAN = (1 << WIDX_W) * 4;

  if (BYTE_PER_LINE) begin : g_byte
    logic [SPAN-1:0] allow_ext;
    always_comb begin
      allow_ext = '0;
      allow_ext[NUM_LINES-1:0] = allow;
    end
    for (genvar k = 0; k < 4; k++) begin : g_lane
      logic [WIDX_W+1:0] line_idx;
      assign line_idx = {word, 2'(k)};
      assign mask[8*k +: 8] = {8{allow_ext[line_idx]}};
    end
  end else begin : g_bit
    logic unused_word;
    assign unused_word = ^word;
    for (genvar b = 0; b < 32; b++) begin : g_pos
      if (b < NUM_LINES) begin : g_live
        assign mask[b] = allow[b];
      end else begin : g_rsvd
        assign mask[b] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lgf_attr_regs.sv
module lgf_attr_regs #(
  parameter int NUM_LINES = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_sec,
  input  logic                 wr_priv,
  input  logic                 wr_lock,
  input  logic                 acc_secure,
  input  logic                 acc_priv,
  input  logic [NUM_LINES-1:0] be_mask,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] sec_q,
  output logic [NUM_LINES-1:0] priv_q,
  output logic                 lock_q
);
  logic [NUM_LINES-1:0] sec_wm, priv_wm;

  always_comb begin
    sec_wm  = {NUM_LINES{acc_secure & ~lock_q}} & (~priv_q | {NUM_LINES{acc_priv}}) & be_mask;
    priv_wm = {NUM_LINES{acc_priv & ~lock_q}} & (~sec_q | {NUM_LINES{acc_secure}}) & be_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      priv_q <= '0;
      lock_q <= 1'b0;
    end else begin
      if (wr_sec)  sec_q  <= (sec_q & ~sec_wm) | (wdata & sec_wm);
      if (wr_priv) priv_q <= (priv_q & ~priv_wm) | (wdata & priv_wm);
      if (wr_lock && acc_secure && wdata[0] && be_mask[0]) lock_q <= 1'b1;
    end
  end

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  p_attr_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(sec_q) && $stable(priv_q)));

  p_sec_nonsecure_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sec && !acc_secure) |=> $stable(sec_q));

  p_priv_unpriv_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_priv && !acc_priv) |=> $stable(priv_q));
endmodule

// File: rtl/line_guard_filter.sv
module line_guard_filter
  import lgf_pkg::*;
#(
  parameter int NUM_LINES = 19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  input  logic        req_secure,
  input  logic        req_priv,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        illegal_pulse,
  output logic        bank_wr_bit,
  output logic        bank_wr_byte,
  output logic [3:0]  bank_word,
  output logic [31:0] bank_wdata,
  input  logic [31:0] bit_bank_rdata,
  input  logic [31:0] byte_bank_rdata
);
  localparam int BYTE_LINES = (1 << WIDX_W) * 4;

  initial begin
    if (NUM_LINES < 1 || NUM_LINES > DATA_W || NUM_LINES > BYTE_LINES)
      $error("NUM_LINES out of range");
  end

  region_e                rgn;
  logic [DATA_W-1:0]      be_mask;
  logic [NUM_LINES-1:0]   sec_q, priv_q, allow;
  logic                   lock_q;
  logic [DATA_W-1:0]      bit_mask, byte_mask, wr_mask, old_word, rd_next;
  logic                   is_wr, illegal_next;
  logic [1:0]             unused_addr;

  assign unused_addr = req_addr[1:0];
  assign rgn       = decode_region(req_addr[ADDR_W-1:2]);
  assign be_mask   = expand_be(req_be);
  assign bank_word = req_addr[WIDX_W+1:2];
  assign is_wr     = req_valid & req_write;

  lgf_attr_regs #(.NUM_LINES(NUM_LINES)) attr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sec    (is_wr && rgn == RGN_SECATTR),
    .wr_priv   (is_wr && rgn == RGN_PRIVATTR),
    .wr_lock   (is_wr && rgn == RGN_LOCK),
    .acc_secure(req_secure),
    .acc_priv  (req_priv),
    .be_mask   (be_mask[NUM_LINES-1:0]),
    .wdata     (req_wdata[NUM_LINES-1:0]),
    .sec_q     (sec_q),
    .priv_q    (priv_q),
    .lock_q    (lock_q)
  );

  lgf_line_rights #(.NUM_LINES(NUM_LINES)) rights_i (
    .sec_attr  (sec_q),
    .priv_attr (priv_q),
    .acc_secure(req_secure),
    .acc_priv  (req_priv),
    .allow     (allow)
  );

  lgf_lane_map #(.NUM_LINES(NUM_LINES), .BYTE_PER_LINE(1'b0), .WIDX_W(WIDX_W)) bitmap_i (
    .allow(allow),
    .word (bank_word),
    .mask (bit_mask)
  );

  lgf_lane_map #(.NUM_LINES(NUM_LINES), .BYTE_PER_LINE(1'b1), .WIDX_W(WIDX_W)) bytemap_i (
    .allow(allow),
    .word (bank_word),
    .mask (byte_mask)
  );

  // Byte-enable merge first, then the per-line protection mask.
  always_comb begin
    if (rgn == RGN_BYTEBANK) begin
      old_word = byte_bank_rdata;
      wr_mask  = byte_mask & be_mask;
    end else begin
      old_word = bit_bank_rdata;
      wr_mask  = bit_mask & be_mask;
    end
    bank_wdata = (req_wdata & wr_mask) | (old_word & ~wr_mask);
  end

  assign bank_wr_bit  = is_wr && rgn == RGN_BITBANK;
  assign bank_wr_byte = is_wr && rgn == RGN_BYTEBANK;

  always_comb begin
    case (rgn)
      RGN_BITBANK:  rd_next = bit_bank_rdata & bit_mask;
      RGN_BYTEBANK: rd_next = byte_bank_rdata & byte_mask;
      RGN_SECATTR:  rd_next = DATA_W'(sec_q);
      RGN_PRIVATTR: rd_next = DATA_W'(priv_q);
      RGN_LOCK:     rd_next = req_secure ? DATA_W'(lock_q) : '0;
      default:      rd_next = '0;
    endcase
  end

  assign illegal_next = req_valid && !req_secure &&
                        ((rgn == RGN_SECATTR && req_write) || rgn == RGN_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      illegal_pulse <= 1'b0;
    end else begin
      rsp_valid     <= req_valid & ~req_write;
      illegal_pulse <= illegal_next;
      if (req_valid && !req_write) rsp_rdata <= rd_next;
    end
  end

  // Protected bits of the bit bank survive writes from weaker accesses.
  p_bit_secure_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr_bit && !req_secure) |-> (((bank_wdata ^ bit_bank_rdata) & DATA_W'(sec_q)) == '0));

  p_bit_priv_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr_bit && !req_priv) |-> (((bank_wdata ^ bit_bank_rdata) & DATA_W'(priv_q)) == '0));

  p_reserved_never_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_bit |-> ((bank_wdata & ~bit_bank_rdata & ~DATA_W'({NUM_LINES{1'b1}})) == '0));

  p_be_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr_bit || bank_wr_byte) |->
      (((bank_wdata ^ (bank_wr_byte ? byte_bank_rdata : bit_bank_rdata)) & ~be_mask) == '0));

  p_illegal_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_pulse |-> $past(req_valid && !req_secure));

  p_rsp_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  p_lock_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(rgn == RGN_LOCK && !req_secure)) |-> (rsp_rdata == '0));
endmodule

// File: tb/line_guard_filter_tb_top.sv
`timescale 1ns/1ps
module line_guard_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0, req_priv = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, illegal_pulse, bank_wr_bit, bank_wr_byte;
  logic [31:0] rsp_rdata, bank_wdata, bit_bank_rdata, byte_bank_rdata;
  logic [3:0]  bank_word;

  logic [31:0] bitb [16];
  logic [31:0] byteb [16];

  assign bit_bank_rdata  = bitb[bank_word];
  assign byte_bank_rdata = byteb[bank_word];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        bitb[i]  <= '0;
        byteb[i] <= '0;
      end
    end else begin
      if (bank_wr_bit)  bitb[bank_word]  <= bank_wdata;
      if (bank_wr_byte) byteb[bank_word] <= bank_wdata;
    end
  end

  line_guard_filter dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .req_secure(req_secure), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .illegal_pulse(illegal_pulse),
    .bank_wr_bit(bank_wr_bit), .bank_wr_byte(bank_wr_byte), .bank_word(bank_word),
    .bank_wdata(bank_wdata), .bit_bank_rdata(bit_bank_rdata), .byte_bank_rdata(byte_bank_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit reported = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    end
  endtask

  // One single-cycle access; checks the response strobe (R11) and the illegal pulse (R10).
  task automatic access(input bit wr, input logic [7:0] a, input logic [3:0] be,
                        input logic [31:0] d, input bit s, input bit p,
                        output logic [31:0] rd);
    bit exp_ill;
    exp_ill = (a[7:2] == 6'h20 && wr && !s) || (a[7:2] == 6'h22 && !s);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be;
    req_wdata = d; req_secure = s; req_priv = p;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    rd = rsp_rdata;
    check("R11 rsp_valid", {31'b0, rsp_valid}, {31'b0, !wr});
    check("R10 illegal_pulse", {31'b0, illegal_pulse}, {31'b0, exp_ill});
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d,
                    input bit s, input bit p);
    logic [31:0] dummy;
    access(1'b1, a, be, d, s, p, dummy);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input bit s, input bit p,
                        input logic [31:0] exp);
    logic [31:0] v;
    access(1'b0, a, 4'hF, 32'h0, s, p, v);
    check(tag, v, exp);
  endtask

  task automatic idle_chk();
    @(negedge clk);
    @(posedge clk);
    #1;
    check("R10 idle illegal low", {31'b0, illegal_pulse}, 32'h0);
    check("R11 idle rsp low", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic t_reset();
    check("R12 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check("R12 reset illegal", {31'b0, illegal_pulse}, 32'h0);
    rd_chk("R12 reset sec attr", 8'h80, 1'b0, 1'b0, 32'h0);
    rd_chk("R12 reset lock", 8'h88, 1'b1, 1'b0, 32'h0);
  endtask

  task automatic t_open();
    wr(8'h08, 4'hF, 32'hFFFF_FFFF, 1'b0, 1'b0);
    rd_chk("R3 open lines writable, reserved zero", 8'h08, 1'b0, 1'b0, 32'h0007_FFFF);
    rd_chk("R12 unmapped reads zero", 8'h90, 1'b1, 1'b1, 32'h0);
  endtask

  task automatic t_secure();
    wr(8'h80, 4'hF, 32'h0000_0028, 1'b1, 1'b1);
    rd_chk("R6 sec attr readable by nonsecure", 8'h80, 1'b0, 1'b0, 32'h0000_0028);
    wr(8'h08, 4'hF, 32'h0, 1'b0, 1'b0);
    rd_chk("R1 secure lines kept", 8'h08, 1'b1, 1'b1, 32'h0000_0028);
    rd_chk("R1 nonsecure read hides secure lines", 8'h08, 1'b0, 1'b0, 32'h0);
    wr(8'h08, 4'hF, 32'hFFFF_FFFF, 1'b0, 1'b0);
    rd_chk("R1 nonsecure read masks 3 and 5", 8'h08, 1'b0, 1'b0, 32'h0007_FFD7);
  endtask

  task automatic t_priv();
    wr(8'h84, 4'hF, 32'h0000_0080, 1'b1, 1'b0);
    rd_chk("R7 unpriv write ignored", 8'h84, 1'b0, 1'b0, 32'h0);
    wr(8'h84, 4'hF, 32'h0000_0088, 1'b0, 1'b1);
    rd_chk("R7 secure line bit needs secure", 8'h84, 1'b0, 1'b0, 32'h0000_0080);
    wr(8'h08, 4'hF, 32'h0, 1'b1, 1'b0);
    rd_chk("R2 priv line kept", 8'h08, 1'b1, 1'b1, 32'h0000_0080);
    rd_chk("R2 unpriv read hides priv line", 8'h08, 1'b1, 1'b0, 32'h0);
  endtask

  task automatic t_sec_attr();
    wr(8'h80, 4'hF, 32'h0, 1'b0, 1'b1);
    rd_chk("R6 nonsecure write ignored", 8'h80, 1'b0, 1'b0, 32'h0000_0028);
    wr(8'h80, 4'hF, 32'h0000_00A0, 1'b1, 1'b0);
    rd_chk("R6 priv line sec bit needs priv", 8'h80, 1'b1, 1'b1, 32'h0000_0020);
    wr(8'h80, 4'hF, 32'h0000_0028, 1'b1, 1'b1);
    rd_chk("R6 restore", 8'h80, 1'b1, 1'b1, 32'h0000_0028);
  endtask

  task automatic t_bytes();
    wr(8'h40, 4'hF, 32'h5500_0000, 1'b1, 1'b0);
    wr(8'h40, 4'hF, 32'h1122_3344, 1'b0, 1'b0);
    rd_chk("R4 lane of secure line kept", 8'h40, 1'b1, 1'b0, 32'h5522_3344);
    rd_chk("R4 nonsecure read hides lane 3", 8'h40, 1'b0, 1'b0, 32'h0022_3344);
    wr(8'h44, 4'hF, 32'hFFFF_FFFF, 1'b0, 1'b0);
    rd_chk("R4 lines 5 and 7 protected", 8'h44, 1'b1, 1'b1, 32'h00FF_00FF);
    wr(8'h50, 4'hF, 32'hAABB_CCDD, 1'b1, 1'b1);
    rd_chk("R4 lane past last line zero", 8'h50, 1'b1, 1'b1, 32'h00BB_CCDD);
    wr(8'h40, 4'b0010, 32'hFFFF_EEFF, 1'b1, 1'b1);
    rd_chk("R5 single byte merge", 8'h40, 1'b1, 1'b1, 32'h5522_EE44);
    wr(8'h08, 4'b0001, 32'hFFFF_FFFF, 1'b1, 1'b1);
    rd_chk("R5 low byte merge in bit bank", 8'h08, 1'b1, 1'b1, 32'h0000_00FF);
  endtask

  task automatic t_lock();
    rd_chk("R8 nonsecure lock read zero", 8'h88, 1'b0, 1'b1, 32'h0);
    idle_chk();
    wr(8'h88, 4'hF, 32'h1, 1'b0, 1'b1);
    rd_chk("R8 nonsecure lock write ignored", 8'h88, 1'b1, 1'b1, 32'h0);
    wr(8'h88, 4'hF, 32'h0, 1'b1, 1'b1);
    rd_chk("R9 writing zero keeps clear", 8'h88, 1'b1, 1'b1, 32'h0);
    wr(8'h88, 4'hF, 32'h1, 1'b1, 1'b1);
    rd_chk("R9 lock set", 8'h88, 1'b1, 1'b1, 32'h1);
    wr(8'h80, 4'hF, 32'h0, 1'b1, 1'b1);
    rd_chk("R9 sec attr frozen", 8'h80, 1'b1, 1'b1, 32'h0000_0028);
    wr(8'h84, 4'hF, 32'h0, 1'b1, 1'b1);
    rd_chk("R9 priv attr frozen", 8'h84, 1'b1, 1'b1, 32'h0000_0080);
    wr(8'h88, 4'hF, 32'h0, 1'b1, 1'b1);
    rd_chk("R9 lock sticky", 8'h88, 1'b1, 1'b1, 32'h1);
    idle_chk();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_open();
    t_secure();
    t_priv();
    t_sec_attr();
    t_bytes();
    t_lock();
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
    $finish;
  end
endmodule